// File: doc/BRIEF.md
# Conditional Decision Evaluator

This block decides three things for a descriptor-driven transfer engine each time a command completes. It decides whether to raise an interrupt, whether to take a branch instead of advancing in sequence, and whether the channel must wait. Each decision compares the four device-status bits against its own programmable select register. A select register holds a 4-bit mask and a 4-bit compare value. The condition for a decision holds when the status bits under the mask equal the compare value under the same mask.

Each decision also takes a 2-bit mode from the current command. The mode says whether the decision is never taken, always taken, taken when the condition holds, or taken when it fails. A host loads the three select registers through a small write port and can read them back. The sequencer presents the device status and the command's mode bits, then pulses an evaluate strobe. One cycle later it reads an interrupt pulse, a take-branch flag (a false flag means advance to the next descriptor) and a must-wait flag.

Top module: `cond_eval_top`

## Requirements
- R1: A write to select register 0 (interrupt), 1 (branch) or 2 (wait) keeps write-data bits 19:16 as the mask and bits 3:0 as the compare value. Reading that register returns them in the same positions, with every other bit zero. Index 3 holds nothing: a write to it changes nothing and it reads as zero.
- R2: A decision's condition is true exactly when (devStatus AND mask) equals (value AND mask). A zero mask therefore makes the condition always true.
- R3: Each mode field uses the encoding 00 = never, 01 = when the condition is true, 10 = when the condition is false, 11 = always. cmdModes bits 5:4 hold the interrupt mode, bits 3:2 the branch mode and bits 1:0 the wait mode.
- R4: irqPulse is high for exactly the one cycle after an evaluate strobe whose interrupt decision is true, and it is low at all other times.
- R5: takeBranch takes the branch decision on the clock edge that samples evalStrobe, and it holds that value until the next strobe.
- R6: mustWait takes the wait decision on the clock edge that samples evalStrobe, and it holds that value until the next strobe.
- R7: Each decision uses only its own select register.
- R8: After reset all select registers read zero and irqPulse, takeBranch and mustWait are low.
- R9: When a register write and an evaluation fall on the same edge, the evaluation uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Select-register write enable |
| regWrIdx | input | 2 | Register index for a write (0 interrupt, 1 branch, 2 wait) |
| regWrData | input | 32 | Write data: mask in 19:16, value in 3:0 |
| regRdIdx | input | 2 | Register index for readback |
| regRdData | output | 32 | Readback of the indexed select register |
| devStatus | input | 4 | Device-status bits |
| cmdModes | input | 6 | Mode fields: interrupt 5:4, branch 3:2, wait 1:0 |
| evalStrobe | input | 1 | Evaluate the three decisions |
| irqPulse | output | 1 | One-cycle interrupt request |
| takeBranch | output | 1 | Branch (1) or sequential advance (0) |
| mustWait | output | 1 | Channel must wait |

## Verification
Random select registers, status bits and mode fields are applied on random cycles. This separates the four modes from one another, and a matching status from a mismatched one, for all three decisions at once. A directed case gives the three decisions different select registers, which exposes any decision that reads a neighbour's register. Other directed cases cover a zero mask and all-ones write data, where masked-out bits must not reach the compare or the readback. A write and an evaluation on the same edge show which register contents the decision used. Cycles with no strobe show whether irqPulse drops back to low while the two flags keep their values.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  localparam int STAT_W   = 4;
  localparam int DATA_W   = 32;
  localparam int MASK_LSB = 16;
  localparam int NUM_DEC  = 3;
  localparam int IDX_W    = 2;
  localparam int MODE_W   = 2;
  localparam int MODES_W  = NUM_DEC * MODE_W;

  // decision index: 0 interrupt, 1 branch, 2 wait
  localparam int DEC_IRQ = 0;
  localparam int DEC_BR  = 1;
  localparam int DEC_WT  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NEVER  = 2'b00,
    MODE_IFSET  = 2'b01,
    MODE_IFCLR  = 2'b10,
    MODE_ALWAYS = 2'b11
  } modeT;

  typedef struct packed {
    logic [NUM_DEC-1:0] wrSel;
    logic               eval;
  } ctlStrobeT;
endpackage

// File: rtl/cond_eval_dp.sv
module cond_eval_dp
  import cond_eval_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobeT             strobes,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [IDX_W-1:0]      rdIdx,
  input  logic [STAT_W-1:0]     devStatus,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_DEC-1:0]    matchVec
);
  logic [STAT_W-1:0] maskQ [NUM_DEC];
  logic [STAT_W-1:0] valQ  [NUM_DEC];

  for (genvar g = 0; g < NUM_DEC; g++) begin : gSel
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[g] <= '0;
        valQ[g]  <= '0;
      end else if (strobes.wrSel[g]) begin
        maskQ[g] <= wrData[MASK_LSB +: STAT_W];
        valQ[g]  <= wrData[STAT_W-1:0];
      end
    end

    assign matchVec[g] = ((devStatus & maskQ[g]) == (valQ[g] & maskQ[g]));

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrSel[g] |=> (maskQ[g] == $past(wrData[MASK_LSB +: STAT_W])) &&
                           (valQ[g] == $past(wrData[STAT_W-1:0]))); // R1
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrSel[g] |=> $stable(maskQ[g]) && $stable(valQ[g])); // R7
  end

  always_comb begin
    rdData = '0;
    if (rdIdx < IDX_W'(NUM_DEC)) begin
      rdData[MASK_LSB +: STAT_W] = maskQ[rdIdx];
      rdData[STAT_W-1:0]         = valQ[rdIdx];
    end
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrSel)); // R1
endmodule

// File: rtl/cond_eval_ctl.sv
module cond_eval_ctl
  import cond_eval_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [IDX_W-1:0]      regWrIdx,
  input  logic                  evalStrobe,
  input  logic [MODES_W-1:0]    cmdModes,
  input  logic [NUM_DEC-1:0]    matchVec,
  output ctlStrobeT             strobes,
  output logic                  irqPulse,
  output logic                  takeBranch,
  output logic                  mustWait
);
  logic [NUM_DEC-1:0] decision;

  always_comb begin
    strobes.eval = evalStrobe;
    for (int i = 0; i < NUM_DEC; i++)
      strobes.wrSel[i] = regWrEn && (regWrIdx == IDX_W'(i));
  end

  for (genvar g = 0; g < NUM_DEC; g++) begin : gDec
    modeT modeG;
    assign modeG = modeT'(cmdModes[g*MODE_W +: MODE_W]);
    always_comb begin
      unique case (modeG)
        MODE_NEVER:  decision[g] = 1'b0;
        MODE_IFSET:  decision[g] = matchVec[g];
        MODE_IFCLR:  decision[g] = !matchVec[g];
        MODE_ALWAYS: decision[g] = 1'b1;
        default:     decision[g] = 1'b0;
      endcase
    end
  end

  // command field order: interrupt high, wait low
  logic decIrq, decBr, decWt;
  assign decIrq = decision[NUM_DEC-1-DEC_IRQ];
  assign decBr  = decision[NUM_DEC-1-DEC_BR];
  assign decWt  = decision[NUM_DEC-1-DEC_WT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse   <= 1'b0;
      takeBranch <= 1'b0;
      mustWait   <= 1'b0;
    end else begin
      irqPulse <= strobes.eval && decIrq;
      if (strobes.eval) begin
        takeBranch <= decBr;
        mustWait   <= decWt;
      end
    end
  end

  AST_IRQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(evalStrobe)); // R4
  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !evalStrobe |=> $stable(takeBranch)); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !evalStrobe |=> $stable(mustWait)); // R6
  AST_IRQ_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    (evalStrobe && cmdModes[5:4] == 2'b00) |=> !irqPulse); // R3
  AST_BRANCH_ALWAYS: assert property (@(posedge clk) disable iff (!rstN)
    (evalStrobe && cmdModes[3:2] == 2'b11) |=> takeBranch); // R3
endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
  import cond_eval_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regWrIdx,
  input  logic [31:0] regWrData,
  input  logic [1:0]  regRdIdx,
  output logic [31:0] regRdData,
  input  logic [3:0]  devStatus,
  input  logic [5:0]  cmdModes,
  input  logic        evalStrobe,
  output logic        irqPulse,
  output logic        takeBranch,
  output logic        mustWait
);
  ctlStrobeT          strobes;
  logic [NUM_DEC-1:0] matchVec;
  logic [NUM_DEC-1:0] matchCmdOrder;

  // datapath index order is interrupt/branch/wait; command order reverses it
  for (genvar g = 0; g < NUM_DEC; g++) begin : gOrd
    assign matchCmdOrder[g] = matchVec[NUM_DEC-1-g];
  end

  cond_eval_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrIdx   (regWrIdx),
    .evalStrobe (evalStrobe),
    .cmdModes   (cmdModes),
    .matchVec   (matchCmdOrder),
    .strobes    (strobes),
    .irqPulse   (irqPulse),
    .takeBranch (takeBranch),
    .mustWait   (mustWait)
  );

  cond_eval_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .rdIdx     (regRdIdx),
    .devStatus (devStatus),
    .rdData    (regRdData),
    .matchVec  (matchVec)
  );
endmodule

// File: tb/cond_eval_top_tb.sv
module cond_eval_top_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regWrIdx;
  logic [31:0] regWrData;
  logic [1:0]  regRdIdx;
  logic [31:0] regRdData;
  logic [3:0]  devStatus;
  logic [5:0]  cmdModes;
  logic        evalStrobe;
  logic        irqPulse, takeBranch, mustWait;

  int errors = 0;
  int checks = 0;
  logic [3:0] mMask [3];
  logic [3:0] mVal  [3];
  logic expIrq, expBr, expWt;

  always #5 clk = ~clk;

  cond_eval_top u_dut (.*);

  function automatic logic decide(input logic [1:0] mode, input logic [3:0] st,
                                  input logic [3:0] m, input logic [3:0] v);
    logic hit;
    hit = ((st & m) == (v & m));
    case (mode)
      2'b00: return 1'b0;
      2'b01: return hit;
      2'b10: return !hit;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model update, sample at next negedge
  task automatic step(input logic wr, input logic [1:0] idx, input logic [31:0] data,
                      input logic ev, input logic [3:0] st, input logic [5:0] md);
    regWrEn = wr; regWrIdx = idx; regWrData = data;
    evalStrobe = ev; devStatus = st; cmdModes = md;
    if (ev) begin
      expIrq = decide(md[5:4], st, mMask[0], mVal[0]);
      expBr  = decide(md[3:2], st, mMask[1], mVal[1]);
      expWt  = decide(md[1:0], st, mMask[2], mVal[2]);
    end else expIrq = 1'b0;
    if (wr && idx != 2'd3) begin
      mMask[idx] = data[19:16];
      mVal[idx]  = data[3:0];
    end
    @(negedge clk);
    regWrEn = 1'b0; evalStrobe = 1'b0;
  endtask

  task automatic checkOuts(input string tag);
    check({tag, " irq R4"}, {31'd0, irqPulse}, {31'd0, expIrq});
    check({tag, " branch R5"}, {31'd0, takeBranch}, {31'd0, expBr});
    check({tag, " wait R6"}, {31'd0, mustWait}, {31'd0, expWt});
  endtask

  task automatic checkRead(input logic [1:0] idx, input string req);
    logic [31:0] e;
    regRdIdx = idx;
    #1;
    e = (idx == 2'd3) ? 32'd0 : {12'd0, mMask[idx], 12'd0, mVal[idx]};
    check(req, regRdData, e);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    for (int i = 0; i < 3; i++) begin mMask[i] = 0; mVal[i] = 0; end
    expIrq = 0; expBr = 0; expWt = 0;
    rstN = 0; regWrEn = 0; regWrIdx = 0; regWrData = 0; regRdIdx = 0;
    devStatus = 0; cmdModes = 0; evalStrobe = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R8 reset state
    for (int i = 0; i < 4; i++) checkRead(2'(i), "R8 reset readback");
    checkOuts("R8 reset");

    // R1 all-ones write keeps only mask and value fields
    step(1, 2'd0, 32'hFFFF_FFFF, 0, 0, 0);
    checkRead(2'd0, "R1 field readback");
    check("R1 exact value", regRdData, 32'h000F_000F);
    step(1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0);
    for (int i = 0; i < 4; i++) checkRead(2'(i), "R1 index3 write ignored");

    // R2 zero mask: condition always true
    step(1, 2'd1, 32'h0000_0005, 0, 0, 0);
    step(0, 0, 0, 1, 4'hA, 6'b00_01_00);
    checkOuts("R2 zero mask ifset");
    check("R2 zero mask branch", {31'd0, takeBranch}, 32'd1);

    // R7 distinct selects per decision
    step(1, 2'd0, 32'h000F_0003, 0, 0, 0);
    step(1, 2'd1, 32'h000F_0005, 0, 0, 0);
    step(1, 2'd2, 32'h000F_0009, 0, 0, 0);
    step(0, 0, 0, 1, 4'h5, 6'b01_01_01);
    checkOuts("R7 separation");
    check("R7 branch only", {29'd0, irqPulse, takeBranch, mustWait}, 32'b010);
    step(0, 0, 0, 0, 4'h0, 6'b11_11_11);
    checkOuts("R4 R5 R6 hold no strobe");

    // R3 each mode on each field
    for (int m = 0; m < 4; m++) begin
      step(0, 0, 0, 1, 4'h3, {2'(m), 2'(m), 2'(m)});
      checkOuts("R3 mode sweep");
    end

    // R9 write and evaluate on the same edge uses old contents
    step(1, 2'd1, 32'h000F_0003, 1, 4'h3, 6'b00_01_00);
    checkOuts("R9 same-edge");
    check("R9 old branch select", {31'd0, takeBranch}, 32'd0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic wr, ev;
      wr = ($urandom_range(0, 3) == 0);
      ev = ($urandom_range(0, 1) == 1);
      step(wr, 2'($urandom), $urandom, ev, 4'($urandom), 6'($urandom));
      checkOuts("random R2 R3 R7");
      if (n % 50 == 0) checkRead(2'($urandom), "R1 random readback");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule